// File: doc/BRIEF.md
# Performance Event Binding Table

This block keeps a small associative map from hardware event identifiers to programmable performance-counter indices. Firmware programs a counter by writing an event selector value together with the counter index. A write with a supported event installs a binding. A write of zero releases every binding that targets that counter. The core sends event pulses that carry an identifier. The table looks each one up in the same cycle and tells the counter bank which counter, if any, should advance.

An identifier is 20 bits wide: a 4-bit type in bits [19:16] and a 16-bit code in bits [15:0]. For cache-type events, the code carries a cache id in bits [15:3], an operation in bits [2:1] and a result flag in bit [0]. The table does not decode these sub-fields. It compares the whole identifier against a fixed list of five supported events and holds one entry per listed event. Each entry has a valid bit and a 5-bit counter index. Several events may point at the same counter.

Top module: `evmap_table`

## Requirements
- R1: Only bits [19:0] of the selector value name the event. Bits above 19 change nothing except that they make the selector nonzero.
- R2: The supported identifiers are 0x00001, 0x00002, 0x10019, 0x1001B and 0x10021. A nonzero selector that names any other identifier raises `wr_err` in the write cycle and leaves the table unchanged.
- R3: The programmable counters are indices FIRST_CTR=3 up to 3+NUM_PROG-1, which is 3..10 by default. A write to any other index raises `wr_err` and leaves the table unchanged, even when the selector value is zero.
- R4: A write to a legal counter with a supported, currently unbound event binds that event to the counter. Lookups see the binding from the next cycle on.
- R5: A write whose event is already bound to any counter raises `wr_ign`, does not raise `wr_err`, and keeps the existing binding.
- R6: A zero selector written to a legal counter removes, by the next cycle, every binding to that counter and no other binding. It raises neither status.
- R7: The lookup is combinational. `lk_hit` and `inc_ctr` reflect the table state before a write made in the same cycle.
- R8: A lookup of an unbound or unsupported identifier gives `lk_hit`=0, `inc_pulse`=0 and `inc_ctr`=0.
- R9: `inc_pulse` equals `ev_pulse` AND `lk_hit`. On a hit, `inc_ctr` is the bound counter index.
- R10: A synchronous active-low reset clears every binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Selector write strobe |
| wr_ctr | input | 5 | Counter index being programmed |
| wr_val | input | 32 | Selector value; bits [19:0] carry the event |
| wr_err | output | 1 | Write rejected (bad counter or unsupported event) |
| wr_ign | output | 1 | Write ignored because the event is already bound |
| ev_pulse | input | 1 | Event occurrence from the core |
| ev_id | input | 20 | Identifier of the event being looked up |
| lk_hit | output | 1 | Identifier currently has a binding |
| inc_pulse | output | 1 | Advance the counter named by inc_ctr |
| inc_ctr | output | 5 | Counter index to advance, zero on a miss |

## Verification
The bench targets rebinding an event that is already mapped: a design that overwrote the entry would move the counter index, and the lookup would show the new counter. It writes zero to a counter that owns two events while a third event stays on another counter. Partial removal, or removal that spreads too far, shows up as the wrong hit pattern afterwards. It uses indices 2 and 3+NUM_PROG, selectors with only high bits set, and identifiers next to the supported codes, to catch off-by-one range checks and loose decoding. A write and a lookup of the same event in one cycle expose a lookup that leaks the incoming value.

// File: rtl/evmap_pkg.sv
// Shared constants for the event binding table: widths and the list of
// supported event identifiers. Assumes a fixed list of five events.
package evmap_pkg;
    localparam int EVT_W   = 20;
    localparam int CTR_W   = 5;
    localparam int NUM_EVT = 5;

    // Return the supported identifier held by slot i.
    function automatic logic [EVT_W-1:0] evt_code(input int i);
        case (i)
            0:       evt_code = 20'h00001;
            1:       evt_code = 20'h00002;
            2:       evt_code = 20'h10019;
            3:       evt_code = 20'h1001B;
            default: evt_code = 20'h10021;
        endcase
    endfunction
endpackage

// File: rtl/evmap_decode.sv
// Whitelist decoder: gives a one-hot slot vector for a supported identifier
// and all zeros otherwise. Assumes the supported identifiers are distinct.
module evmap_decode
    import evmap_pkg::*;
(
    input  logic [EVT_W-1:0]   evt,
    output logic [NUM_EVT-1:0] slot_oh
);
    // one full-width comparator per supported identifier
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_cmp
        assign slot_oh[i] = (evt == evt_code(i));
    end
endmodule

// File: rtl/evmap_slot.sv
// One table entry: a valid bit and the bound counter index. Assumes the
// parent never asserts set and clear in the same cycle.
module evmap_slot
    import evmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [CTR_W-1:0] set_ctr,
    input  logic             clr_en,
    input  logic [CTR_W-1:0] clr_ctr,
    output logic             vld,
    output logic [CTR_W-1:0] ctr
);
    logic clr_hit;
    assign clr_hit = clr_en && vld && (ctr == clr_ctr);

    // entry update: reset clears, set binds, a matching release unbinds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            ctr <= '0;
        end else if (set) begin
            vld <= 1'b1;
            ctr <= set_ctr;
        end else if (clr_hit) begin
            vld <= 1'b0;
        end
    end

    // R6
    unbind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && vld && ctr == clr_ctr) |=> !vld);

    // R4
    set_keeps_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (vld && ctr == $past(set_ctr)));
endmodule

// File: rtl/evmap_table.sv
// Event-to-counter binding table. Selector writes bind, release or are
// rejected. Lookups are combinational against the registered table.
// Assumes 3+NUM_PROG <= 2**CTR_W and one write per cycle.
module evmap_table
    import evmap_pkg::*;
#(
    parameter int NUM_PROG  = 8,
    parameter int FIRST_CTR = 3,
    parameter int SEL_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_ctr,
    input  logic [SEL_W-1:0] wr_val,
    output logic             wr_err,
    output logic             wr_ign,
    input  logic             ev_pulse,
    input  logic [EVT_W-1:0] ev_id,
    output logic             lk_hit,
    output logic             inc_pulse,
    output logic [CTR_W-1:0] inc_ctr
);
    localparam int LAST_P1 = FIRST_CTR + NUM_PROG;
    localparam logic [CTR_W:0] LO_B = CTR_W'(FIRST_CTR);
    localparam logic [CTR_W:0] HI_B = (CTR_W+1)'(LAST_P1);

    logic [NUM_EVT-1:0]            wr_oh, lk_oh, vld_vec, set_vec, lk_vec;
    logic [NUM_EVT-1:0][CTR_W-1:0] slot_ctr;
    logic ctr_ok, sel_zero, known, bound, do_set, do_clr;

    evmap_decode u_wr_dec (.evt(wr_val[EVT_W-1:0]), .slot_oh(wr_oh));
    evmap_decode u_lk_dec (.evt(ev_id),             .slot_oh(lk_oh));

    // classify the incoming selector write
    always_comb begin
        ctr_ok   = ({1'b0, wr_ctr} >= LO_B) && ({1'b0, wr_ctr} < HI_B);
        sel_zero = (wr_val == '0);
        known    = |wr_oh;
        bound    = |(wr_oh & vld_vec);
        wr_err   = wr_en && (!ctr_ok || (!sel_zero && !known));
        wr_ign   = wr_en && ctr_ok && !sel_zero && bound;
        do_set   = wr_en && ctr_ok && !sel_zero && known && !bound;
        do_clr   = wr_en && ctr_ok && sel_zero;
        set_vec  = do_set ? wr_oh : '0;
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_slot
        evmap_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .set(set_vec[i]), .set_ctr(wr_ctr),
            .clr_en(do_clr), .clr_ctr(wr_ctr),
            .vld(vld_vec[i]), .ctr(slot_ctr[i])
        );
    end

    // lookup: select the bound index of the matching valid slot
    always_comb begin
        lk_vec  = lk_oh & vld_vec;
        lk_hit  = |lk_vec;
        inc_ctr = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (lk_vec[i]) inc_ctr = inc_ctr | slot_ctr[i];
        end
        inc_pulse = ev_pulse && lk_hit;
    end

    // R2 R3
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> ($stable(vld_vec) && $stable(slot_ctr)));

    // R5
    ign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ign |=> ($stable(vld_vec) && $stable(slot_ctr)));

    // R5
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_err && wr_ign));

    // R8
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!inc_pulse && inc_ctr == '0));

    // R9
    inc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse |-> ({1'b0, inc_ctr} >= LO_B && {1'b0, inc_ctr} < HI_B));

    // R4
    bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && !wr_ign && wr_val != '0) |=> |(vld_vec & $past(wr_oh)));
endmodule

// File: tb/evmap_table_bench.sv
// Bench with a behavioural reference model compared on every clock.
module evmap_table_bench;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_ctr = '0;
    logic [31:0] wr_val = '0;
    logic        ev_pulse = 1'b0;
    logic [19:0] ev_id = '0;
    logic        wr_err, wr_ign, lk_hit, inc_pulse;
    logic [4:0]  inc_ctr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model: per supported event, bound flag and counter
    bit m_vld [5];
    int m_ctr [5];

    always #5 clk = ~clk;

    evmap_table #(.NUM_PROG(NP)) u_evmap_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_val(wr_val),
        .wr_err(wr_err), .wr_ign(wr_ign), .ev_pulse(ev_pulse), .ev_id(ev_id),
        .lk_hit(lk_hit), .inc_pulse(inc_pulse), .inc_ctr(inc_ctr)
    );

    function automatic int ev_slot(input logic [19:0] e);
        case (e)
            20'h00001: return 0;
            20'h00002: return 1;
            20'h10019: return 2;
            20'h1001B: return 3;
            20'h10021: return 4;
            default:   return -1;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, compare against the model, then advance the model
    task automatic step(input bit we, input int c, input logic [31:0] v,
                        input bit ep, input logic [19:0] eid);
        int s, ls, ec;
        bit cok, eh;
        @(negedge clk);
        wr_en = we; wr_ctr = 5'(c); wr_val = v; ev_pulse = ep; ev_id = eid;
        #1;
        s   = ev_slot(v[19:0]);
        cok = (c >= 3) && (c < 3 + NP);
        chk("R2/R3 wr_err", int'(wr_err), int'(we && (!cok || (v != 0 && s < 0))));
        chk("R5 wr_ign", int'(wr_ign), int'(we && cok && v != 0 && s >= 0 && m_vld[s]));
        ls = ev_slot(eid);
        eh = (ls >= 0) && m_vld[ls];
        ec = eh ? m_ctr[ls] : 0;
        chk("R7/R8 lk_hit", int'(lk_hit), int'(eh));
        chk("R8/R9 inc_ctr", int'(inc_ctr), ec);
        chk("R9 inc_pulse", int'(inc_pulse), int'(ep && eh));
        if (we && cok) begin
            if (v == 0) begin
                for (int i = 0; i < 5; i++) if (m_vld[i] && m_ctr[i] == c) m_vld[i] = 0;
            end else if (s >= 0 && !m_vld[s]) begin
                m_vld[s] = 1; m_ctr[s] = c;
            end
        end
    endtask

    task automatic look(input logic [19:0] e);
        step(0, 0, 0, 1, e);
    endtask

    task automatic look_all();
        look(20'h00001); look(20'h00002); look(20'h10019);
        look(20'h1001B); look(20'h10021);
    endtask

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        logic [19:0] pick [8];
        pick = '{20'h00001, 20'h00002, 20'h10019, 20'h1001B,
                 20'h10021, 20'h10020, 20'h00003, 20'h1001A};
        for (int i = 0; i < 5; i++) begin m_vld[i] = 0; m_ctr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: nothing bound after reset
        look_all();
        // R4: bind cycles to counter 3, visible next cycle
        step(1, 3, 32'h1, 0, 0);
        look(20'h00001);
        // R5: rebinding an already bound event keeps counter 3
        step(1, 5, 32'h1, 0, 0);
        look(20'h00001);
        step(1, 3, 32'h10019, 0, 0);
        step(1, 4, 32'h10021, 0, 0);
        // R2: unsupported neighbours rejected
        step(1, 6, 32'h10020, 0, 0);
        step(1, 6, 32'h1001A, 0, 0);
        step(1, 6, 32'h00100000, 0, 0);
        // R1: high bits ignored for event selection
        step(1, 6, 32'hF0000002, 0, 0);
        look(20'h00002);
        // R3: counter range edges
        step(1, 2, 32'h1001B, 0, 0);
        step(1, 3 + NP, 32'h1001B, 0, 0);
        step(1, 3 + NP - 1, 32'h1001B, 1, 20'h1001B);
        look(20'h1001B);
        step(1, 1, 32'h0, 0, 0);
        // R6: release counter 3 (two events), counter 4 untouched
        step(1, 3, 32'h0, 0, 0);
        look_all();
        // R7: write and lookup of the same event in one cycle
        step(1, 7, 32'h1, 1, 20'h00001);
        look(20'h00001);
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            lfsr = nxt(lfsr);
            step(lfsr[0], int'(lfsr[5:1]) & 15,
                 lfsr[6] ? 32'h0 : {(lfsr[7] ? 12'hA00 : 12'h0), pick[lfsr[10:8]]},
                 lfsr[11], pick[lfsr[14:12]]);
        end
        // R10: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0; wr_en = 0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 5; i++) m_vld[i] = 0;
        look_all();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule